// File: doc/BRIEF.md
# I2C SCL Clock Generator

This block turns a fast system clock into a free-running SCL square wave for an I2C controller. Timing comes from two stages. A prescaler divides the system clock by a power of two, set by a small exponent field, and produces a one-cycle base tick. A phase counter then counts base ticks. SCL is held high for one programmed number of ticks and then low for another.

Each phase length is programmed as "ticks minus one", so an all-zero field still gives a one-tick phase and the divider can never be zero. The full SCL period is 2^B × ((H + 1) + (L + 1)) system clocks. A one-cycle pulse accompanies every SCL transition, so surrounding control logic can align data changes and sampling to the clock edges. The block does not generate START or STOP conditions, does not handle clock stretching and does not arbitrate the bus.

Top module: `scl_clkgen`

## Requirements
- R1: While `en` is low, `scl_o` is 1 one clock after `en` is sampled low, `edge_o` is 0, and the prescaler and phase counters are held at zero.
- R2: The settings on `div_exp`, `hi_cnt` and `lo_cnt` at the last clock edge with `en` low are the settings used after enable. The first phase after enable is high. `scl_o` first falls at the 2^B·(H+1)-th clock edge at which `en` is sampled high.
- R3: Every high phase lasts exactly 2^B·(H+1) system clocks.
- R4: Every low phase lasts exactly 2^B·(L+1) system clocks.
- R5: A field value of zero gives one base tick. With B=0, H=0 and L=0, SCL toggles on every clock, for a 2-clock period.
- R6: `edge_o` is high for exactly the one cycle in which `scl_o` shows a new level, and is never high otherwise.
- R7: New field values are taken only at the end of a full period, which is the end of a low phase. A change made during a period does not alter that period. The next period uses the new values.
- R8: `div_exp` is 4 bits wide. B=15 gives a base tick every 32768 clocks.
- R9: The `hi_cnt` and `lo_cnt` width CNT_W is 3 or 4. An all-ones field gives 2^CNT_W ticks, which is 16 ticks at the default CNT_W=4.
- R10: Dropping `en` in the middle of a period abandons that period. Re-enabling starts again with a full-length high phase.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| en | input | 1 | Run enable; low holds SCL high and clears the counters |
| div_exp | input | EXP_W (4) | Base tick exponent B; a tick occurs every 2^B clocks |
| hi_cnt | input | CNT_W | High phase length minus one, in base ticks |
| lo_cnt | input | CNT_W | Low phase length minus one, in base ticks |
| scl_o | output | 1 | SCL level |
| edge_o | output | 1 | One-cycle pulse on every SCL transition |

## Verification
The bound checker watches several properties on every cycle:
- SCL is parked high with no pulse while the block is disabled.
- The edge pulse and the SCL transitions match exactly.
- The captured settings stay still except at a period end or while disabled.
- Base ticks are never back to back unless the exponent is zero.

Exact phase lengths, the first-fall latency after enable, the hand-over of new settings at the period boundary, the largest exponent, all-ones count fields and restart after a mid-period disable can only be shown by the bench scenarios. The bench measures the spacing between edge pulses against 2^B·(N+1).

// File: rtl/scl_pkg.sv
package scl_pkg;
    // Width of the base-divisor exponent field
    localparam int unsigned SCL_EXP_W = 4;

    // Current SCL phase
    typedef enum logic {
        PH_HIGH = 1'b0,
        PH_LOW  = 1'b1
    } scl_phase_e;
endpackage

// File: rtl/scl_cfg_hold.sv
// Shadow copy of the timing fields; follows the inputs while disabled,
// otherwise reloads only at the end of a full SCL period.
module scl_cfg_hold #(
    parameter int unsigned EXP_W = scl_pkg::SCL_EXP_W,
    parameter int unsigned CNT_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             en,
    input  logic             reload,
    input  logic [EXP_W-1:0] exp_i,
    input  logic [CNT_W-1:0] hi_i,
    input  logic [CNT_W-1:0] lo_i,
    output logic [EXP_W-1:0] exp_o,
    output logic [CNT_W-1:0] hi_o,
    output logic [CNT_W-1:0] lo_o
);
    typedef struct packed {
        logic [EXP_W-1:0] exp;
        logic [CNT_W-1:0] hi;
        logic [CNT_W-1:0] lo;
    } cfg_t;

    cfg_t cfg_d, cfg_q;

    always_comb begin
        cfg_d = cfg_q;
        if (!en || reload) begin
            cfg_d.exp = exp_i;
            cfg_d.hi  = hi_i;
            cfg_d.lo  = lo_i;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cfg_q <= '0;
        end else begin
            cfg_q <= cfg_d;
        end
    end

    assign exp_o = cfg_q.exp;
    assign hi_o  = cfg_q.hi;
    assign lo_o  = cfg_q.lo;
endmodule

// File: rtl/scl_prescaler.sv
// Power-of-two prescaler: tick every 2^exp enabled clocks.
module scl_prescaler #(
    parameter int unsigned EXP_W = scl_pkg::SCL_EXP_W
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             en,
    input  logic [EXP_W-1:0] exp_i,
    output logic             tick_o
);
    // Largest exponent is 2^EXP_W-1, so the counter needs that many bits
    localparam int unsigned PW = (1 << EXP_W) - 1;

    typedef struct packed {
        logic [PW-1:0] cnt;
    } pre_t;

    pre_t pre_d, pre_q;
    logic [PW:0]   lim_full;
    logic [PW-1:0] limit;
    logic          tick;

    always_comb begin
        lim_full = ((PW+1)'(1) << exp_i) - (PW+1)'(1);
        limit    = lim_full[PW-1:0];
        tick     = en && (pre_q.cnt == limit);
        pre_d    = pre_q;
        if (!en) begin
            pre_d.cnt = '0;
        end else if (tick) begin
            pre_d.cnt = '0;
        end else begin
            pre_d.cnt = pre_q.cnt + PW'(1);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pre_q <= '0;
        end else begin
            pre_q <= pre_d;
        end
    end

    assign tick_o = tick;
endmodule

// File: rtl/scl_phase.sv
// High/low phase counter driven by base ticks.
module scl_phase #(
    parameter int unsigned CNT_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             en,
    input  logic             tick_i,
    input  logic [CNT_W-1:0] hi_i,
    input  logic [CNT_W-1:0] lo_i,
    output logic             scl_o,
    output logic             edge_o,
    output logic             period_end_o
);
    import scl_pkg::*;

    typedef struct packed {
        scl_phase_e       phase;
        logic [CNT_W-1:0] cnt;
        logic             edg;
    } ph_t;

    localparam ph_t PH_IDLE = '{phase: PH_HIGH, cnt: '0, edg: 1'b0};

    ph_t ph_d, ph_q;
    logic [CNT_W-1:0] target;
    logic             last_tick;

    always_comb begin
        target    = (ph_q.phase == PH_HIGH) ? hi_i : lo_i;
        last_tick = en && tick_i && (ph_q.cnt == target);
        ph_d      = ph_q;
        ph_d.edg  = 1'b0;
        if (!en) begin
            ph_d = PH_IDLE;
        end else if (tick_i) begin
            if (ph_q.cnt == target) begin
                ph_d.phase = (ph_q.phase == PH_HIGH) ? PH_LOW : PH_HIGH;
                ph_d.cnt   = '0;
                ph_d.edg   = 1'b1;
            end else begin
                ph_d.cnt = ph_q.cnt + CNT_W'(1);
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ph_q <= PH_IDLE;
        end else begin
            ph_q <= ph_d;
        end
    end

    assign scl_o        = (ph_q.phase == PH_HIGH);
    assign edge_o       = ph_q.edg;
    assign period_end_o = last_tick && (ph_q.phase == PH_LOW);
endmodule

// File: rtl/scl_clkgen.sv
// SCL clock generator top.
module scl_clkgen #(
    parameter int unsigned EXP_W = scl_pkg::SCL_EXP_W,
    parameter int unsigned CNT_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             en,
    input  logic [EXP_W-1:0] div_exp,
    input  logic [CNT_W-1:0] hi_cnt,
    input  logic [CNT_W-1:0] lo_cnt,
    output logic             scl_o,
    output logic             edge_o
);
    logic [EXP_W-1:0] cfg_exp;
    logic [CNT_W-1:0] cfg_hi;
    logic [CNT_W-1:0] cfg_lo;
    logic             tick;
    logic             period_end;

    scl_cfg_hold #(.EXP_W(EXP_W), .CNT_W(CNT_W)) u_cfg (
        .clk    (clk),
        .rst_n  (rst_n),
        .en     (en),
        .reload (period_end),
        .exp_i  (div_exp),
        .hi_i   (hi_cnt),
        .lo_i   (lo_cnt),
        .exp_o  (cfg_exp),
        .hi_o   (cfg_hi),
        .lo_o   (cfg_lo)
    );

    scl_prescaler #(.EXP_W(EXP_W)) u_pre (
        .clk    (clk),
        .rst_n  (rst_n),
        .en     (en),
        .exp_i  (cfg_exp),
        .tick_o (tick)
    );

    scl_phase #(.CNT_W(CNT_W)) u_ph (
        .clk          (clk),
        .rst_n        (rst_n),
        .en           (en),
        .tick_i       (tick),
        .hi_i         (cfg_hi),
        .lo_i         (cfg_lo),
        .scl_o        (scl_o),
        .edge_o       (edge_o),
        .period_end_o (period_end)
    );
endmodule

// File: rtl/scl_clkgen_chk.sv
module scl_clkgen_chk #(
    parameter int unsigned EXP_W = 4,
    parameter int unsigned CNT_W = 4
) (
    input logic             clk,
    input logic             rst_n,
    input logic             en,
    input logic             scl_o,
    input logic             edge_o,
    input logic             tick,
    input logic             period_end,
    input logic [EXP_W-1:0] cfg_exp,
    input logic [CNT_W-1:0] cfg_hi,
    input logic [CNT_W-1:0] cfg_lo
);
    // R1
    disabled_parked_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !en |=> (scl_o && !edge_o));

    // R6
    edge_marks_change_chk: assert property (@(posedge clk) disable iff (!rst_n)
        edge_o |-> (scl_o != $past(scl_o)));

    // R6
    change_has_edge_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((scl_o != $past(scl_o)) && $past(en)) |-> edge_o);

    // R7
    cfg_held_in_period_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(en) && !$past(period_end)) |->
            ($stable(cfg_exp) && $stable(cfg_hi) && $stable(cfg_lo)));

    // R3
    tick_spacing_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (en && $past(en) && tick && $past(tick)) |->
            ((cfg_exp == '0) || !$stable(cfg_exp)));
endmodule

bind scl_clkgen scl_clkgen_chk #(.EXP_W(EXP_W), .CNT_W(CNT_W)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .en         (en),
    .scl_o      (scl_o),
    .edge_o     (edge_o),
    .tick       (tick),
    .period_end (period_end),
    .cfg_exp    (cfg_exp),
    .cfg_hi     (cfg_hi),
    .cfg_lo     (cfg_lo)
);

// File: tb/sim_scl_clkgen.sv
module sim_scl_clkgen;
    localparam int CLK_PERIOD = 10;
    localparam int EXP_W      = 4;
    localparam int CNT_W      = 4;
    localparam int EDGE_LIMIT = 40000;
    localparam int RUN_LIMIT  = 195000;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             en = 1'b0;
    logic [EXP_W-1:0] div_exp = '0;
    logic [CNT_W-1:0] hi_cnt = '0;
    logic [CNT_W-1:0] lo_cnt = '0;
    logic             scl_w;
    logic             edg_w;

    int    n_checks = 0;
    int    n_errors = 0;
    longint cycnt = 0;
    longint c0;
    bit    done = 1'b0;

    scl_clkgen #(.EXP_W(EXP_W), .CNT_W(CNT_W)) u0 (
        .clk     (clk),
        .rst_n   (rst_n),
        .en      (en),
        .div_exp (div_exp),
        .hi_cnt  (hi_cnt),
        .lo_cnt  (lo_cnt),
        .scl_o   (scl_w),
        .edge_o  (edg_w)
    );

    always #(CLK_PERIOD/2) clk = ~clk;
    always @(posedge clk) cycnt <= cycnt + 1;

    function automatic longint phase_len(int b, int n);
        return (longint'(1) << b) * longint'(n + 1);
    endfunction

    task automatic check(bit ok, string req, longint act, longint exp);
        n_checks++;
        if (!ok) begin
            n_errors++;
            $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic finish_run();
        $display("  Result: errors=%0d of %0d checks", n_errors, n_checks);
        $finish;
    endtask

    // Wait for the next edge pulse; return its cycle and the new SCL level
    task automatic wait_edge(output longint cyc, output logic lvl);
        int n = 0;
        do begin
            @(negedge clk);
            n++;
        end while (!edg_w && n < EDGE_LIMIT);
        if (!edg_w) begin
            n_checks++;
            n_errors++;
            $display("FAIL timeout: actual=no edge expected=edge");
        end
        cyc = cycnt;
        lvl = scl_w;
    endtask

    // Disable, set fields, then enable; c0 marks the enabling negedge
    task automatic start(int b, int h, int l);
        @(negedge clk);
        en      = 1'b0;
        div_exp = EXP_W'(b);
        hi_cnt  = CNT_W'(h);
        lo_cnt  = CNT_W'(l);
        @(negedge clk);
        en = 1'b1;
        c0 = cycnt;
    endtask

    // Measure first fall, rise, and second fall for one setting
    task automatic run_case(int b, int h, int l, string tag);
        longint t1, t2, t3;
        logic   v1, v2, v3;
        start(b, h, l);
        wait_edge(t1, v1);
        check(t1 - c0 == phase_len(b, h), {tag, " R2 first fall"}, t1 - c0, phase_len(b, h));
        check(v1 == 1'b0, {tag, " R6 fall level"}, v1, 0);
        wait_edge(t2, v2);
        check(t2 - t1 == phase_len(b, l), {tag, " R4 low len"}, t2 - t1, phase_len(b, l));
        check(v2 == 1'b1, {tag, " R6 rise level"}, v2, 1);
        wait_edge(t3, v3);
        check(t3 - t2 == phase_len(b, h), {tag, " R3 high len"}, t3 - t2, phase_len(b, h));
    endtask

    initial begin
        wait (cycnt >= RUN_LIMIT);
        if (!done) begin
            n_checks++;
            n_errors++;
            $display("FAIL watchdog: actual=%0d expected<%0d", cycnt, RUN_LIMIT);
            finish_run();
        end
    end

    initial begin
        longint ta, tb, tc, td;
        logic   la, lb, lc, ld;
        void'($urandom(32'd20240611));

        repeat (3) @(negedge clk);
        check(scl_w == 1'b1, "R1 reset scl", scl_w, 1);
        check(edg_w == 1'b0, "R1 reset edge", edg_w, 0);
        rst_n = 1'b1;

        // R1: disabled while fields wiggle
        for (int i = 0; i < 20; i++) begin
            @(negedge clk);
            div_exp = EXP_W'($urandom);
            hi_cnt  = CNT_W'($urandom);
            lo_cnt  = CNT_W'($urandom);
            check(scl_w == 1'b1 && edg_w == 1'b0, "R1 disabled idle", {scl_w, edg_w}, 2);
        end

        // R5: all-zero fields toggle every clock
        run_case(0, 0, 0, "zero");
        // R9: all-ones count fields give 16 ticks
        run_case(0, 15, 15, "ones");
        run_case(1, 0, 7, "mixed");

        // R7: change fields during the first high phase
        start(2, 5, 3);
        repeat (5) @(negedge clk);
        div_exp = 4'd1;
        hi_cnt  = 4'd2;
        lo_cnt  = 4'd9;
        wait_edge(ta, la);
        check(ta - c0 == phase_len(2, 5), "R7 old high kept", ta - c0, phase_len(2, 5));
        wait_edge(tb, lb);
        check(tb - ta == phase_len(2, 3), "R7 old low kept", tb - ta, phase_len(2, 3));
        wait_edge(tc, lc);
        check(tc - tb == phase_len(1, 2), "R7 new high used", tc - tb, phase_len(1, 2));
        wait_edge(td, ld);
        check(td - tc == phase_len(1, 9), "R7 new low used", td - tc, phase_len(1, 9));

        // R10: drop enable during a low phase, then restart
        start(3, 2, 6);
        wait_edge(ta, la);
        repeat (10) @(negedge clk);
        en = 1'b0;
        @(negedge clk);
        check(scl_w == 1'b1 && edg_w == 1'b0, "R10 R1 abort parks high", {scl_w, edg_w}, 2);
        repeat (3) @(negedge clk);
        check(scl_w == 1'b1, "R10 stays high", scl_w, 1);
        en = 1'b1;
        c0 = cycnt;
        wait_edge(tb, lb);
        check(tb - c0 == phase_len(3, 2), "R10 full high after restart", tb - c0, phase_len(3, 2));

        // Random settings
        for (int i = 0; i < 24; i++) begin
            int b = int'($urandom_range(0, 5));
            int h = int'($urandom_range(0, 15));
            int l = int'($urandom_range(0, 15));
            run_case(b, h, l, "rand");
        end

        // R8: largest exponent
        start(15, 0, 0);
        wait_edge(ta, la);
        check(ta - c0 == 64'd32768, "R8 max exponent high", ta - c0, 32768);
        @(negedge clk);
        en = 1'b0;

        done = 1'b1;
        finish_run();
    end
endmodule